// File: doc/BRIEF.md
# Converter Power Mode Controller

This block decides, frame by frame, whether the core of a serial sampling converter and its internal reference are powered. It runs on a free-running system clock. It takes single-cycle event pulses from the serial front end: chip select falling, chip select rising, the first falling serial-clock edge of a frame, and the sixteenth rising serial-clock edge. It also takes the two-bit power-mode code and the reference-disable bit from the configuration register. It drives `core_on` and `ref_on`.

A wake counter holds `ready` low after every power-up until the wake delay has passed. The delay is long when the reference was off and has to start. It is short when the reference stayed powered (standby), or when the reference-disable bit is set. A sample strobe that arrives while `ready` is low marks the frame's result as invalid. A new configuration written during a frame is adopted at that frame's chip-select rise. All delays are expressed in microseconds and scaled by a cycles-per-microsecond parameter.

Top module: `pm_power_ctrl`

## Requirements
- R1: After reset the applied mode is 00 and the applied reference-disable bit is 0. `core_on`, `ref_on`, `ready` and `result_invalid` are all 0.
- R2: In mode 00, a `cs_fall` pulse turns the core and reference on from the next cycle. A `cs_rise` pulse turns both off from the next cycle, even if the frame has had no sixteenth rising edge.
- R3: In mode 01, the core and reference stay on. `cs_rise`, `cs_fall` and the serial-clock pulses never turn them off.
- R4: In mode 10, `sclk_last_rise` turns the core and reference off and `sclk_first_fall` turns them on. `cs_fall` and `cs_rise` do not change the power state unless the mode changes.
- R5: In mode 11, `sclk_last_rise` turns the core off while the reference stays on, and `sclk_first_fall` turns the core on again.
- R6: When the core powers up with the reference previously off and reference-disable 0, `ready` rises exactly LONG_WAKE_US*CYC_PER_US cycles after `core_on` rises.
- R7: When the core powers up with the reference already on (standby), or with the applied reference-disable bit at 1, `ready` rises exactly SHORT_WAKE_US*CYC_PER_US cycles after `core_on` rises.
- R8: `ready` falls in the same cycle as `core_on` falls, and is never high while `core_on` is low.
- R9: A `hold_strobe` pulse seen while `ready` is 0 sets `result_invalid` from the next cycle until the next `cs_fall`. A strobe seen while `ready` is 1 leaves it at 0.
- R10: `ref_on` is 0 whenever the applied reference-disable bit is 1, in every mode.
- R11: `mode_code` and `ref_dis` are applied only on a `cs_rise` pulse; until then the previous mode governs. When the applied mode changes, the power state goes to the new mode's idle state: 00 all off, 01 all on, 10 all off, 11 core off with the reference on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_code | input | 2 | Power-mode code from the configuration register |
| ref_dis | input | 1 | Reference-disable bit from the configuration register |
| cs_fall | input | 1 | One-cycle pulse on chip-select falling |
| cs_rise | input | 1 | One-cycle pulse on chip-select rising (frame end) |
| sclk_first_fall | input | 1 | One-cycle pulse on the frame's first falling serial-clock edge |
| sclk_last_rise | input | 1 | One-cycle pulse on the frame's sixteenth rising serial-clock edge |
| hold_strobe | input | 1 | One-cycle pulse when the input sample is held |
| core_on | output | 1 | Converter core power enable |
| ref_on | output | 1 | Internal reference power enable |
| ready | output | 1 | Core powered and wake delay elapsed |
| result_invalid | output | 1 | Current frame sampled before ready |

## Verification
The hardest situation to reach is the short-delay wake. It needs either a core wake from standby, which takes a frame in mode 11 ending on a sixteenth rising edge, or an applied reference-disable bit. Both are only adopted at a chip-select rise. The bench therefore writes each configuration mid-frame, closes the frame so that the new mode's idle state is reached, and then issues the wake pulse. It places scoreboard expectations exactly one cycle before and at the delay boundary. The same flow covers a mode change from 11 straight to 01 with the reference disabled. In that case the wake caused by the mode change itself must take the short delay.

// File: rtl/pm_pkg.sv
package pm_pkg;
   typedef enum logic [1:0] {
      PM_CS_GATED = 2'b00,
      PM_ALWAYS   = 2'b01,
      PM_AUTO_OFF = 2'b10,
      PM_AUTO_STBY = 2'b11
   } pm_mode_e;

   typedef struct packed {
      pm_mode_e mode;
      logic     ref_dis;
   } pm_cfg_t;

   localparam pm_cfg_t PM_CFG_RESET = '{mode: PM_CS_GATED, ref_dis: 1'b0};
endpackage

// File: rtl/pm_cfg_stage.sv
module pm_cfg_stage
   import pm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    apply,
   input  pm_cfg_t cfg_in,
   output pm_cfg_t cfg_q
);
   // configuration is adopted only at frame end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= PM_CFG_RESET;
      else if (apply) cfg_q <= cfg_in;
   end
endmodule

// File: rtl/pm_power_fsm.sv
module pm_power_fsm
   import pm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  pm_cfg_t cfg_q,
   input  pm_cfg_t cfg_in,
   input  logic    cs_fall,
   input  logic    cs_rise,
   input  logic    first_fall,
   input  logic    last_rise,
   output logic    core_q,
   output logic    ref_q,
   output logic    wake,
   output logic    short_sel
);
   logic core_n, ref_n;
   logic mode_switch;

   assign mode_switch = cs_rise && (cfg_in.mode != cfg_q.mode);

   always_comb begin
      core_n    = core_q;
      ref_n     = ref_q;
      short_sel = ref_q | cfg_q.ref_dis;
      if (mode_switch) begin
         short_sel = ref_q | cfg_in.ref_dis;
         unique case (cfg_in.mode)
            PM_CS_GATED:  begin core_n = 1'b0; ref_n = 1'b0; end
            PM_ALWAYS:    begin core_n = 1'b1; ref_n = 1'b1; end
            PM_AUTO_OFF:  begin core_n = 1'b0; ref_n = 1'b0; end
            PM_AUTO_STBY: begin core_n = 1'b0; ref_n = 1'b1; end
         endcase
      end else begin
         unique case (cfg_q.mode)
            PM_CS_GATED: begin
               if (cs_rise)      begin core_n = 1'b0; ref_n = 1'b0; end
               else if (cs_fall) begin core_n = 1'b1; ref_n = 1'b1; end
            end
            PM_ALWAYS: begin
               core_n = 1'b1;
               ref_n  = 1'b1;
            end
            PM_AUTO_OFF: begin
               if (last_rise)       begin core_n = 1'b0; ref_n = 1'b0; end
               else if (first_fall) begin core_n = 1'b1; ref_n = 1'b1; end
            end
            PM_AUTO_STBY: begin
               ref_n = 1'b1;
               if (last_rise)       core_n = 1'b0;
               else if (first_fall) core_n = 1'b1;
            end
         endcase
      end
   end

   assign wake = core_n & ~core_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_q <= 1'b0;
         ref_q  <= 1'b0;
      end else begin
         core_q <= core_n;
         ref_q  <= ref_n;
      end
   end
endmodule

// File: rtl/pm_wake_timer.sv
module pm_wake_timer #(
   parameter int LONG_CYC  = 1000,
   parameter int SHORT_CYC = 200,
   parameter int CNT_W     = $clog2(LONG_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic core_q,
   input  logic wake,
   input  logic short_sel,
   output logic ready
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   generate
      if (SHORT_CYC == LONG_CYC) begin : g_single_delay
         logic unused_sel;
         assign unused_sel = short_sel;
         assign load_val   = CNT_W'(LONG_CYC);
      end else begin : g_dual_delay
         assign load_val = short_sel ? CNT_W'(SHORT_CYC) : CNT_W'(LONG_CYC);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (wake)            cnt_q <= load_val;
      else if (!core_q)         cnt_q <= '0;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign ready = core_q && (cnt_q == '0);
endmodule

// File: rtl/pm_power_ctrl.sv
module pm_power_ctrl
   import pm_pkg::*;
#(
   parameter int CYC_PER_US    = 200,
   parameter int LONG_WAKE_US  = 5,
   parameter int SHORT_WAKE_US = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_code,
   input  logic       ref_dis,
   input  logic       cs_fall,
   input  logic       cs_rise,
   input  logic       sclk_first_fall,
   input  logic       sclk_last_rise,
   input  logic       hold_strobe,
   output logic       core_on,
   output logic       ref_on,
   output logic       ready,
   output logic       result_invalid
);
   localparam int LONG_CYC  = CYC_PER_US * LONG_WAKE_US;
   localparam int SHORT_CYC = CYC_PER_US * SHORT_WAKE_US;
   localparam int CNT_W     = $clog2(LONG_CYC + 1);

   generate
      if (CYC_PER_US < 1 || SHORT_WAKE_US < 1 || SHORT_WAKE_US > LONG_WAKE_US) begin : g_bad_params
         $error("pm_power_ctrl: wake delay parameters out of range");
      end
   endgenerate

   pm_cfg_t cfg_in, cfg_q;
   logic    ref_alive, wake, short_sel, inval_q;

   assign cfg_in = '{mode: pm_mode_e'(mode_code), ref_dis: ref_dis};

   pm_cfg_stage u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .apply  (cs_rise),
      .cfg_in (cfg_in),
      .cfg_q  (cfg_q)
   );

   pm_power_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_q      (cfg_q),
      .cfg_in     (cfg_in),
      .cs_fall    (cs_fall),
      .cs_rise    (cs_rise),
      .first_fall (sclk_first_fall),
      .last_rise  (sclk_last_rise),
      .core_q     (core_on),
      .ref_q      (ref_alive),
      .wake       (wake),
      .short_sel  (short_sel)
   );

   pm_wake_timer #(
      .LONG_CYC  (LONG_CYC),
      .SHORT_CYC (SHORT_CYC),
      .CNT_W     (CNT_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_q    (core_on),
      .wake      (wake),
      .short_sel (short_sel),
      .ready     (ready)
   );

   // frame-scoped flag: a sample held before ready taints this frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    inval_q <= 1'b0;
      else if (hold_strobe && !ready) inval_q <= 1'b1;
      else if (cs_fall)              inval_q <= 1'b0;
   end

   assign result_invalid = inval_q;
   assign ref_on         = ref_alive & ~cfg_q.ref_dis;
endmodule

// File: rtl/pm_power_ctrl_chk.sv
module pm_power_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_fall,
   input logic       cs_rise,
   input logic       sclk_last_rise,
   input logic       hold_strobe,
   input logic       core_on,
   input logic       ref_on,
   input logic       ready,
   input logic       result_invalid,
   input logic       ref_alive,
   input logic [1:0] act_mode,
   input logic [1:0] in_mode
);
   // R8
   pwr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_on) |-> !ready);

   // R6
   wake_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_on) |-> !ready);

   // R2
   cs_rise_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && act_mode == 2'b00 && in_mode == 2'b00) |=> (!core_on && !ref_on));

   // R3
   always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == 2'b01 && !cs_rise) |=> core_on);

   // R4
   auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == 2'b10 && !cs_rise && sclk_last_rise) |=> (!core_on && !ref_alive));

   // R5
   standby_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == 2'b11 && !cs_rise && sclk_last_rise) |=> (!core_on && ref_alive));

   // R9
   invalid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_strobe && !ready && !cs_fall) |=> result_invalid);
endmodule

bind pm_power_ctrl pm_power_ctrl_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cs_fall        (cs_fall),
   .cs_rise        (cs_rise),
   .sclk_last_rise (sclk_last_rise),
   .hold_strobe    (hold_strobe),
   .core_on        (core_on),
   .ref_on         (ref_on),
   .ready          (ready),
   .result_invalid (result_invalid),
   .ref_alive      (ref_alive),
   .act_mode       (cfg_q.mode),
   .in_mode        (mode_code)
);

// File: tb/tb_pm_power_ctrl.sv
module tb_pm_power_ctrl;
   localparam int CPU = 200;
   localparam int DL  = CPU * 5;
   localparam int DS  = CPU * 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_code = 2'b00;
   logic       ref_dis = 1'b0;
   logic       cs_fall = 1'b0, cs_rise = 1'b0;
   logic       sclk_first_fall = 1'b0, sclk_last_rise = 1'b0;
   logic       hold_strobe = 1'b0;
   logic       core_on, ref_on, ready, result_invalid;

   int cyc = 0;
   int checks = 0;
   int failures = 0;
   int t = 0;
   bit done = 1'b0;

   typedef struct {
      int cyc; int req; int core; int refv; int rdy; int inv;
   } exp_t;
   exp_t sb_q[$];

   pm_power_ctrl #(.CYC_PER_US(CPU), .LONG_WAKE_US(5), .SHORT_WAKE_US(1)) dut (
      .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .ref_dis(ref_dis),
      .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_first_fall(sclk_first_fall),
      .sclk_last_rise(sclk_last_rise), .hold_strobe(hold_strobe),
      .core_on(core_on), .ref_on(ref_on), .ready(ready), .result_invalid(result_invalid));

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic cmp(input int req, input string nm, input int act, input int exp_v);
      if (exp_v >= 0) begin
         checks++;
         if (act != exp_v) begin
            failures++;
            $display("FAIL R%0d %s at cycle %0d: actual=%0d expected=%0d", req, nm, cyc, act, exp_v);
         end
      end
   endtask

   // monitor: pops every scoreboard item due in this cycle
   always @(negedge clk) begin
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
         if (sb_q[i].cyc == cyc) begin
            cmp(sb_q[i].req, "core_on", int'(core_on), sb_q[i].core);
            cmp(sb_q[i].req, "ref_on", int'(ref_on), sb_q[i].refv);
            cmp(sb_q[i].req, "ready", int'(ready), sb_q[i].rdy);
            cmp(sb_q[i].req, "result_invalid", int'(result_invalid), sb_q[i].inv);
            sb_q.delete(i);
         end
      end
   end

   task automatic push(input int c, input int req, input int co, input int rf,
                       input int rd, input int iv);
      exp_t e;
      e.cyc = c; e.req = req; e.core = co; e.refv = rf; e.rdy = rd; e.inv = iv;
      sb_q.push_back(e);
   endtask

   // which: 0 cs_fall, 1 cs_rise, 2 first fall, 3 last rise, 4 hold
   task automatic ev(input int which);
      @(posedge clk); #1;
      case (which)
         0: cs_fall = 1'b1;
         1: cs_rise = 1'b1;
         2: sclk_first_fall = 1'b1;
         3: sclk_last_rise = 1'b1;
         default: hold_strobe = 1'b1;
      endcase
      t = cyc + 1;
      @(posedge clk); #1;
      cs_fall = 1'b0; cs_rise = 1'b0; sclk_first_fall = 1'b0;
      sclk_last_rise = 1'b0; hold_strobe = 1'b0;
   endtask

   task automatic set_cfg(input logic [1:0] m, input logic rd);
      @(posedge clk); #1;
      mode_code = m; ref_dis = rd;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      // R1 reset state
      push(cyc + 1, 1, 0, 0, 0, 0);
      push(cyc + 3, 1, 0, 0, 0, 0);
      idle(5);

      // R2 mode 00 wake on cs_fall, R6 long delay
      ev(0);
      push(t, 2, 1, 1, 0, -1);
      push(t + DL - 1, 6, 1, 1, 0, -1);
      push(t + DL, 6, 1, 1, 1, -1);
      idle(DL + 3);
      // R9 strobe while ready leaves flag clear
      ev(4);
      push(t + 1, 9, -1, -1, 1, 0);
      idle(3);
      // R2 cs_rise mid-frame powers down, R8 ready drops together
      ev(1);
      push(t, 2, 0, 0, 0, -1);
      push(t, 8, 0, -1, 0, -1);
      idle(3);

      // R9 early strobe marks frame invalid
      ev(0);
      ev(4);
      push(t + 1, 9, 1, 1, 0, 1);
      idle(3);
      // R11 new mode written mid-frame has no effect yet
      set_cfg(2'b10, 1'b0);
      idle(5);
      push(cyc + 1, 11, 1, 1, -1, 1);
      idle(3);
      ev(1);
      // R11 switch to mode 10 idle: all off
      push(t, 11, 0, 0, 0, 1);
      idle(3);

      // R4 mode 10: cs_fall has no power effect; R9 flag cleared
      ev(0);
      push(t, 4, 0, 0, 0, 0);
      idle(2);
      ev(2);
      push(t, 4, 1, 1, 0, -1);
      push(t + DL - 1, 6, 1, 1, 0, -1);
      push(t + DL, 6, 1, 1, 1, -1);
      idle(DL + 3);
      ev(3);
      push(t, 4, 0, 0, 0, -1);
      push(t, 8, 0, 0, 0, -1);
      idle(2);
      set_cfg(2'b11, 1'b0);
      ev(1);
      // R11 switch to mode 11 idle: reference only
      push(t, 11, 0, 1, 0, -1);
      idle(3);

      // R5 mode 11 standby wake, R7 short delay
      ev(0);
      push(t, 5, 0, 1, 0, -1);
      ev(2);
      push(t, 5, 1, 1, 0, -1);
      push(t + DS - 1, 7, 1, 1, 0, -1);
      push(t + DS, 7, 1, 1, 1, -1);
      idle(DS + 3);
      ev(3);
      push(t, 5, 0, 1, 0, -1);
      idle(2);
      set_cfg(2'b11, 1'b1);
      ev(1);
      // R10 applied disable bit forces reference output low
      push(t, 10, 0, 0, 0, -1);
      idle(3);

      // R11 mode 11 -> 01 with disable set: on, R7 short delay, R10
      set_cfg(2'b01, 1'b1);
      ev(0);
      ev(1);
      push(t, 10, 1, 0, 0, -1);
      push(t + DS - 1, 7, 1, 0, 0, -1);
      push(t + DS, 7, 1, 0, 1, -1);
      idle(DS + 3);
      // R3 mode 01 ignores frame events
      ev(3);
      push(t, 3, 1, 0, 1, -1);
      ev(1);
      push(t, 3, 1, 0, 1, -1);
      ev(0);
      push(t, 3, 1, 0, 1, -1);
      idle(2);
      set_cfg(2'b01, 1'b0);
      ev(1);
      // R10 disable cleared at frame end restores reference
      push(t, 10, 1, 1, 1, -1);
      idle(3);

      // R7 mode 10 wake with disable set uses short delay
      set_cfg(2'b10, 1'b1);
      ev(1);
      push(t, 11, 0, 0, 0, -1);
      idle(2);
      ev(2);
      push(t, 7, 1, 0, 0, -1);
      push(t + DS - 1, 7, 1, 0, 0, -1);
      push(t + DS, 7, 1, 0, 1, -1);
      idle(DS + 5);

      if (sb_q.size() != 0) begin
         failures++;
         $display("FAIL R0 scoreboard: actual=%0d pending expected=0", sb_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule